// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers the single-cycle event pulses of a network controller into one level interrupt line. Each event pulse latches a sticky cause bit. A separate enable mask decides which latched causes may raise the interrupt. Software clears cause bits by writing ones to them.

The mask is never written as a whole word. One register offset turns mask bits on, and a second offset turns them off. In both cases only the one bits of the write data act, so a zero in the write data never changes the mask. Reading the set offset returns the current mask.

Eleven bit positions are implemented. All other positions are reserved: they read as zero, ignore writes and ignore events. Writes on the register bus complete in the cycle they are presented. Read data is a combinational function of the address and the current state. The bus has no back-pressure and no handshake: every write is taken, and every read answers in the same cycle.

Top module: `icm_ctrl`

## Requirements
- R1: After reset the mask and the cause register are all zeros and `irq` is 0.
- R2: A write to the mask-set offset (0x04) sets every implemented mask bit whose write-data bit is 1. The new mask is readable at offset 0x04 the cycle after the write.
- R3: In a write to the mask-set offset, a write-data bit of 0 leaves its mask bit unchanged. This holds for bits that are currently 1.
- R4: A write of 1 to a bit at the mask-clear offset (0x08) clears that mask bit, and a write of 0 there leaves the bit unchanged. Reads at 0x08, and at any offset other than 0x00 and 0x04, return 0.
- R5: Reading the cause offset (0x00) returns the latched cause bits. Reading the mask-set offset returns the mask.
- R6: Only bits 28, 27, 26, 23, 21, 20, 16, 15, 7, 6 and 4 are implemented; this set is 0x1CB180D0. Every other bit of the mask and of the cause register reads 0 and is unaffected by writes and by event pulses.
- R7: An event pulse on an implemented bit sets that cause bit. The bit stays set until a write of 1 to it at the cause offset.
- R8: When an event pulse and a cause clear hit the same bit in the same cycle, the bit stays set.
- R9: `irq` is registered. It equals the OR over all bits of (cause AND mask), as that value stood one cycle earlier.
- R10: Setting a mask bit whose cause is already latched asserts `irq` one cycle after the mask update. Clearing that mask bit deasserts `irq` one cycle after the update and leaves the cause bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, taken in the same cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_pulse | input | 32 | One-cycle event pulses, one per cause bit |
| irq | output | 1 | Level interrupt request |

## Verification
The timing of each result is fixed by the design. A register write or an event pulse is sampled at edge k. The mask or cause change is visible on `bus_rdata` right after edge k, because the read path adds no register. `irq` follows at edge k+1, because it is registered from the state that edge k wrote.

The bench drives every input on the falling edge. Each table step applies one operation for one cycle and then leaves one idle cycle. It reads the state back on a later falling edge, after both edges have passed. The directed timing test samples `irq` on the falling edges just before and just after edge k+1. This shows the exact one-cycle delay.

// File: rtl/icm_pkg.sv
package icm_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;

  // implemented bit positions; everything else is reserved
  localparam logic [DATA_W-1:0] IMPL_BITS = 32'h1CB1_80D0;

  localparam logic [ADDR_W-1:0] OFF_CAUSE = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_MSET  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_MCLR  = 8'h08;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_MSET  = 2'd2,
    SEL_MCLR  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic cause_clr;
    logic mask_set;
    logic mask_clr;
  } wr_strobes_t;

endpackage

// File: rtl/icm_reg_decode.sv
module icm_reg_decode
  import icm_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter logic [AW-1:0] A_CAUSE = OFF_CAUSE,
  parameter logic [AW-1:0] A_MSET  = OFF_MSET,
  parameter logic [AW-1:0] A_MCLR  = OFF_MCLR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] cause_q,
  input  logic [DW-1:0] mask_q,
  output wr_strobes_t   stb,
  output logic [DW-1:0] rdata
);

  reg_sel_e sel;

  always_comb begin
    if (addr == A_CAUSE)      sel = SEL_CAUSE;
    else if (addr == A_MSET)  sel = SEL_MSET;
    else if (addr == A_MCLR)  sel = SEL_MCLR;
    else                      sel = SEL_NONE;
  end

  always_comb begin
    stb.cause_clr = we && (sel == SEL_CAUSE);
    stb.mask_set  = we && (sel == SEL_MSET);
    stb.mask_clr  = we && (sel == SEL_MCLR);
  end

  always_comb begin
    unique case (sel)
      SEL_CAUSE: rdata = cause_q;
      SEL_MSET:  rdata = mask_q;
      default:   rdata = '0;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({stb.cause_clr, stb.mask_set, stb.mask_clr}) <= 1); // R4
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_MCLR) |-> (rdata == '0)); // R4
  AST_MSET_READS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_MSET) |-> (rdata == mask_q)); // R5

endmodule

// File: rtl/icm_mask_bank.sv
module icm_mask_bank
  import icm_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter logic [DW-1:0] IMPL = IMPL_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_stb,
  input  logic          clr_stb,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_q
);

  logic [DW-1:0] set_vec;
  logic [DW-1:0] clr_vec;

  assign set_vec = set_stb ? (wdata & IMPL) : '0;
  assign clr_vec = clr_stb ? wdata : '0;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bit_q <= 1'b0;
      else if (set_vec[i]) bit_q <= 1'b1;
      else if (clr_vec[i]) bit_q <= 1'b0;
    end
    assign mask_q[i] = bit_q;
  end

  AST_MASK_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((mask_q & $past(wdata & IMPL)) == $past(wdata & IMPL))); // R2
  AST_MASK_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && !clr_stb) |=> ((mask_q & $past(mask_q)) == $past(mask_q))); // R3
  AST_MASK_CLR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !set_stb) |=> ((mask_q & $past(wdata)) == '0)); // R4
  AST_MASK_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & ~IMPL) == '0); // R6

endmodule

// File: rtl/icm_cause_bank.sv
module icm_cause_bank
  import icm_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter logic [DW-1:0] IMPL = IMPL_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt,
  input  logic          clr_stb,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cause_q
);

  logic [DW-1:0] evt_live;
  logic [DW-1:0] clr_vec;

  assign evt_live = evt & IMPL;
  assign clr_vec  = clr_stb ? wdata : '0;

  // event beats clear in the same cycle
  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           bit_q <= 1'b0;
      else if (evt_live[i]) bit_q <= 1'b1;
      else if (clr_vec[i])  bit_q <= 1'b0;
    end
    assign cause_q[i] = bit_q;
  end

  AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_live != '0) |=> ((cause_q & $past(evt_live)) == $past(evt_live))); // R8
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stb |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R7
  AST_CAUSE_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q & ~IMPL) == '0); // R6

endmodule

// File: rtl/icm_irq_out.sv
module icm_irq_out
  import icm_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cause_q,
  input  logic [DW-1:0] mask_q,
  output logic          irq
);

  logic [DW-1:0] pending;
  logic          irq_q;

  assign pending = cause_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pending;
  end

  assign irq = irq_q;

endmodule

// File: rtl/icm_ctrl.sv
module icm_ctrl
  import icm_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter logic [DW-1:0] IMPL = IMPL_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] evt_pulse,
  output logic          irq
);

  wr_strobes_t   stb;
  logic [DW-1:0] cause_q;
  logic [DW-1:0] mask_q;

  icm_reg_decode #(.DW(DW), .AW(AW)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (bus_addr),
    .we      (bus_we),
    .cause_q (cause_q),
    .mask_q  (mask_q),
    .stb     (stb),
    .rdata   (bus_rdata)
  );

  icm_mask_bank #(.DW(DW), .IMPL(IMPL)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (stb.mask_set),
    .clr_stb (stb.mask_clr),
    .wdata   (bus_wdata),
    .mask_q  (mask_q)
  );

  icm_cause_bank #(.DW(DW), .IMPL(IMPL)) u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt_pulse),
    .clr_stb (stb.cause_clr),
    .wdata   (bus_wdata),
    .cause_q (cause_q)
  );

  icm_irq_out #(.DW(DW)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .cause_q (cause_q),
    .mask_q  (mask_q),
    .irq     (irq)
  );

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((cause_q & mask_q) != '0)); // R9
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q & mask_q) != '0) |=> irq); // R9
  AST_MCLR_KEEPS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.mask_clr && (evt_pulse == '0)) |=> (cause_q == $past(cause_q))); // R10

endmodule

// File: tb/icm_ctrl_test.sv
module icm_ctrl_test;

  localparam logic [7:0]  A_CAUSE = 8'h00;
  localparam logic [7:0]  A_MSET  = 8'h04;
  localparam logic [7:0]  A_MCLR  = 8'h08;
  localparam logic [31:0] IMPL    = 32'h1CB1_80D0;

  typedef struct packed {
    logic        is_evt;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp_mask;
    logic [31:0] exp_cause;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, A_MSET,  32'h0000_00D0, 32'h0000_00D0, 32'h0000_0000, 1'b0}, // R2
    '{1'b0, A_MSET,  32'h0000_0000, 32'h0000_00D0, 32'h0000_0000, 1'b0}, // R3
    '{1'b1, 8'h00,   32'h0000_0040, 32'h0000_00D0, 32'h0000_0040, 1'b1}, // R7
    '{1'b0, A_MCLR,  32'h0000_0040, 32'h0000_0090, 32'h0000_0040, 1'b0}, // R10
    '{1'b0, A_MSET,  32'hFFFF_FFFF, IMPL,          32'h0000_0040, 1'b1}, // R6
    '{1'b0, A_CAUSE, 32'h0000_0040, IMPL,          32'h0000_0000, 1'b0}, // R7
    '{1'b1, 8'h00,   32'hFFFF_FFFF, IMPL,          IMPL,          1'b1}, // R6
    '{1'b0, A_MCLR,  32'hFFFF_FFFF, 32'h0000_0000, IMPL,          1'b0}, // R4
    '{1'b0, A_CAUSE, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b0}  // R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] evt_pulse = '0;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  icm_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_pulse (evt_pulse),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(A_MSET, v);  chk("R1 mask", v, 32'h0);
    rd(A_CAUSE, v); chk("R1 cause", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;

    // table walk: op one cycle, one idle cycle, then read back
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (VEC[i].is_evt) evt_pulse = VEC[i].data;
      else begin
        bus_addr = VEC[i].addr; bus_we = 1'b1; bus_wdata = VEC[i].data;
      end
      @(negedge clk);
      evt_pulse = '0; bus_we = 1'b0; bus_wdata = '0;
      @(negedge clk);
      rd(A_MSET, v);  chk($sformatf("R5 mask step %0d", i), v, VEC[i].exp_mask);
      rd(A_CAUSE, v); chk($sformatf("R5 cause step %0d", i), v, VEC[i].exp_cause);
      chk($sformatf("R9 irq step %0d", i), {31'b0, irq}, {31'b0, VEC[i].exp_irq});
    end

    // R4: clear offset and unmapped offset read 0 while mask is non-zero
    wr(A_MSET, 32'h0001_8000);
    rd(A_MCLR, v);  chk("R4 clear offset reads 0", v, 32'h0);
    rd(8'h0C, v);   chk("R4 unmapped reads 0", v, 32'h0);
    wr(A_MCLR, 32'h0000_8000);
    rd(A_MSET, v);  chk("R4 clear one bit", v, 32'h0001_0000);

    // R6: write only reserved bits to set offset
    wr(A_MCLR, 32'hFFFF_FFFF);
    wr(A_MSET, ~IMPL);
    rd(A_MSET, v);  chk("R6 reserved set ignored", v, 32'h0);
    @(negedge clk); evt_pulse = ~IMPL;
    @(negedge clk); evt_pulse = '0;
    rd(A_CAUSE, v); chk("R6 reserved events ignored", v, 32'h0);

    // R8: event and clear of the same bit in one cycle
    @(negedge clk); evt_pulse = 32'h0000_0080;
    @(negedge clk);
    bus_addr = A_CAUSE; bus_we = 1'b1; bus_wdata = 32'h0000_0080;
    @(negedge clk); evt_pulse = '0; bus_we = 1'b0; bus_wdata = '0;
    rd(A_CAUSE, v); chk("R8 event wins over clear", v, 32'h0000_0080);
    wr(A_CAUSE, 32'h0000_0080);
    rd(A_CAUSE, v); chk("R7 cleared by write 1", v, 32'h0);

    // R9: exact one-cycle delay of irq after a cause update
    wr(A_MSET, 32'h0000_0010);
    @(negedge clk); evt_pulse = 32'h0000_0010;
    @(negedge clk); evt_pulse = '0;
    chk("R9 irq not yet high", {31'b0, irq}, 32'h0);
    rd(A_CAUSE, v); chk("R9 cause set", v, 32'h0000_0010);
    @(negedge clk);
    chk("R9 irq high one cycle later", {31'b0, irq}, 32'h1);

    // R10: mask clear drops irq one cycle later and keeps cause
    @(negedge clk);
    bus_addr = A_MCLR; bus_we = 1'b1; bus_wdata = 32'h0000_0010;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
    chk("R10 irq still high", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R10 irq low", {31'b0, irq}, 32'h0);
    rd(A_CAUSE, v); chk("R10 cause kept", v, 32'h0000_0010);
    // R10: re-enable with cause latched
    @(negedge clk);
    bus_addr = A_MSET; bus_we = 1'b1; bus_wdata = 32'h0000_0010;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
    chk("R10 irq waits a cycle", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 irq on re-enable", {31'b0, irq}, 32'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule